// File: doc/BRIEF.md
# Monitor Channel Handshake Controller

This block moves multi-byte messages over the byte-wide monitor slot that a time-division serial bus carries once per frame. It contains a transmitter and a receiver that share one bus position: each frame the block offers one data byte and two active-low handshake bits, MX (byte valid) and MR (byte acknowledged). It samples the same three fields from the far end. The frame strobe `frm_tick` marks the one clock in each frame in which the incoming slot fields are valid. The outgoing fields that are present on that clock are the ones the far end sees in that frame.

The host starts a message by writing a byte while the channel is not active. It waits for the data-acknowledged pulse before it writes each further byte. After the last acknowledged byte it asks for end of message. The receiver accepts a byte only after the same value has been seen with MX active in two consecutive frames. It reports each accepted byte with a valid strobe and flags end of message when MX stays inactive for two frames. The host on the receiving side can abort a transfer. The transmitter recognises that abort and also ends any byte that is not acknowledged within a programmable number of frames, unless the timeout is disabled.

Top module: `mon_handshake_ctl`

## Requirements
- R1: After reset, tx_mx and tx_mr are 1 (inactive), tx_active is 0, and every pulse output is 0.
- R2: A host_wr while tx_active is 0 sets tx_active to 1 on the next clock and drives tx_mx to 0 with tx_mon equal to host_wdata.
- R3: The receiver accepts a byte only when rx_mx is 0 with the same rx_mon value in two consecutive frames. It then pulses rx_valid for one clock with rx_data equal to that byte and drives tx_mr to 0. A byte that differs from the previous frame is not accepted.
- R4: While a byte is being sent, the first frame with rx_mr equal to 0 gives a one-clock tx_ack_irq pulse. The transmitter then keeps tx_mx at 0 with the same byte until the host acts.
- R5: A host_wr after the acknowledge drives tx_mx to 1 with the new byte on tx_mon for exactly one frame, then drives tx_mx to 0.
- R6: A host_wr while a byte waits for its acknowledge is ignored, and tx_mon keeps the original byte.
- R7: After acknowledging a byte, the receiver sets tx_mr to 1 in the first frame with rx_mx equal to 1. A second consecutive frame with rx_mx equal to 1 gives a one-clock rx_eom pulse.
- R8: A host_eom after the acknowledge drives tx_mx to 1. tx_active returns to 0 once two frames have passed and rx_mr has been seen at 1.
- R9: An rx_abort_req while the receiver holds tx_mr at 0 sets tx_mr to 1. The receiver then gives no rx_eom and accepts no byte until rx_mx has been 1 for two consecutive frames, after which it accepts new messages.
- R10: While holding an acknowledged byte, two consecutive frames with rx_mr equal to 1 give a one-clock tx_abort pulse, return tx_active to 0 and set tx_mx to 1.
- R11: With tmo_dis at 0, a byte that has no acknowledge in the tmo_frames-th frame after it starts (tmo_frames at least 1) gives one-clock tx_tmo and tx_abort pulses and ends the transfer. With tmo_dis at 1, the transmitter waits indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frm_tick | input | 1 | One-clock frame strobe; the rx slot fields are valid here |
| host_wr | input | 1 | Host byte write strobe |
| host_wdata | input | 8 | Host byte to send |
| host_eom | input | 1 | Host end-of-message request |
| tmo_dis | input | 1 | 1 disables the timeout |
| tmo_frames | input | TMO_W | Frames allowed for an acknowledge |
| rx_abort_req | input | 1 | Host request to abort the incoming transfer |
| rx_mon | input | 8 | Incoming monitor byte |
| rx_mx | input | 1 | Incoming MX, active low |
| rx_mr | input | 1 | Incoming MR, active low |
| tx_mon | output | 8 | Outgoing monitor byte |
| tx_mx | output | 1 | Outgoing MX, active low |
| tx_mr | output | 1 | Outgoing MR, active low |
| tx_active | output | 1 | Transmit channel busy |
| tx_ack_irq | output | 1 | Data-acknowledged pulse |
| tx_abort | output | 1 | Transfer aborted pulse |
| tx_tmo | output | 1 | Timeout pulse |
| rx_valid | output | 1 | Received-byte strobe |
| rx_data | output | 8 | Received byte |
| rx_eom | output | 1 | End-of-message pulse |

## Verification
The checker confirms on every clock the following: an acknowledge pulse follows only a frame with MR active; an accepted byte follows a frame with MX active and carries that frame's byte, with MR driven active at the same moment; an idle or aborted transmitter holds MX inactive; a timeout is always an abort; and the outgoing byte cannot change while MX stays active. The frame counts cannot be seen from a single cycle: acknowledge after three frames, one gap frame between bytes, two frames to end of message or abort, and the exact timeout frame. The same holds for the rejection of a byte that changes between frames and for the receiver's return to normal operation after an abort. Only the bench scenarios show these, with the block looped back onto itself or driven by a modelled far end.

// File: rtl/mon_hs_pkg.sv
package mon_hs_pkg;

    localparam int MON_W = 8;

    // Handshake bits are active low on the bus
    localparam logic LVL_ACT  = 1'b0;
    localparam logic LVL_IDLE = 1'b1;

    typedef logic [MON_W-1:0] mon_byte_t;

    // What the receiver looks at in one frame
    typedef struct packed {
        mon_byte_t data;
        logic      mx;
    } rx_slot_t;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_SEND,
        TX_HOLD,
        TX_GAP,
        TX_END
    } tx_st_e;

    typedef enum logic [1:0] {
        RX_WAIT,
        RX_ACKED,
        RX_GAP,
        RX_ABORT
    } rx_st_e;

    // Byte counts as stable: MX active now and last frame, same value
    function automatic logic seen_twice(rx_slot_t cur, rx_slot_t prv);
        return (cur.mx == LVL_ACT) && (prv.mx == LVL_ACT) && (cur.data == prv.data);
    endfunction

endpackage

// File: rtl/mon_hs_tx.sv
module mon_hs_tx
    import mon_hs_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             host_wr,
    input  mon_byte_t        host_wdata,
    input  logic             host_eom,
    input  logic             tmo_dis,
    input  logic [TMO_W-1:0] tmo_frames,
    input  logic             far_mr,
    output mon_byte_t        mon_o,
    output logic             mx_o,
    output logic             active_o,
    output logic             ack_o,
    output logic             abort_o,
    output logic             tmo_o
);

    tx_st_e           st;
    mon_byte_t        cur_byte;
    logic [TMO_W-1:0] cnt;
    logic             tmo_hit;

    assign tmo_hit  = !tmo_dis && (({1'b0, cnt} + 1'b1) >= {1'b0, tmo_frames});
    assign mon_o    = cur_byte;
    assign mx_o     = (st == TX_SEND || st == TX_HOLD) ? LVL_ACT : LVL_IDLE;
    assign active_o = (st != TX_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= TX_IDLE;
            cur_byte <= '0;
            cnt      <= '0;
            ack_o    <= 1'b0;
            abort_o  <= 1'b0;
            tmo_o    <= 1'b0;
        end else begin
            ack_o   <= 1'b0;
            abort_o <= 1'b0;
            tmo_o   <= 1'b0;
            if (host_wr && (st == TX_IDLE || st == TX_HOLD)) begin
                cur_byte <= host_wdata;
                cnt      <= '0;
                st       <= (st == TX_IDLE) ? TX_SEND : TX_GAP;
            end else if (host_eom && st == TX_HOLD) begin
                cnt <= '0;
                st  <= TX_END;
            end else if (tick) begin
                case (st)
                    TX_SEND: begin
                        if (far_mr == LVL_ACT) begin
                            ack_o <= 1'b1;
                            cnt   <= '0;
                            st    <= TX_HOLD;
                        end else if (tmo_hit) begin
                            tmo_o   <= 1'b1;
                            abort_o <= 1'b1;
                            st      <= TX_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    TX_HOLD: begin
                        if (far_mr == LVL_IDLE) begin
                            if (cnt != '0) begin
                                abort_o <= 1'b1;
                                st      <= TX_IDLE;
                            end else begin
                                cnt <= TMO_W'(1);
                            end
                        end else begin
                            cnt <= '0;
                        end
                    end
                    TX_GAP: begin
                        cnt <= '0;
                        st  <= TX_SEND;
                    end
                    TX_END: begin
                        if (cnt == '0)
                            cnt <= TMO_W'(1);
                        else if (far_mr == LVL_IDLE)
                            st <= TX_IDLE;
                    end
                    default: st <= TX_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/mon_hs_rx.sv
module mon_hs_rx
    import mon_hs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  rx_slot_t  slot_i,
    input  logic      abort_req,
    output logic      mr_o,
    output logic      valid_o,
    output mon_byte_t data_o,
    output logic      eom_o
);

    rx_st_e   st;
    rx_slot_t prv;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= RX_WAIT;
            prv     <= '{data: '0, mx: LVL_IDLE};
            mr_o    <= LVL_IDLE;
            valid_o <= 1'b0;
            data_o  <= '0;
            eom_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            eom_o   <= 1'b0;
            if (tick) begin
                prv <= slot_i;
                case (st)
                    RX_WAIT: begin
                        if (seen_twice(slot_i, prv)) begin
                            valid_o <= 1'b1;
                            data_o  <= slot_i.data;
                            mr_o    <= LVL_ACT;
                            st      <= RX_ACKED;
                        end
                    end
                    RX_ACKED: begin
                        if (slot_i.mx == LVL_IDLE) begin
                            mr_o <= LVL_IDLE;
                            st   <= RX_GAP;
                        end
                    end
                    RX_GAP: begin
                        if (slot_i.mx == LVL_IDLE)
                            eom_o <= 1'b1;
                        st <= RX_WAIT;
                    end
                    RX_ABORT: begin
                        if (slot_i.mx == LVL_IDLE && prv.mx == LVL_IDLE)
                            st <= RX_WAIT;
                    end
                    default: st <= RX_WAIT;
                endcase
            end else if (abort_req && st == RX_ACKED) begin
                mr_o <= LVL_IDLE;
                st   <= RX_ABORT;
            end
        end
    end

endmodule

// File: rtl/mon_handshake_ctl.sv
module mon_handshake_ctl
    import mon_hs_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frm_tick,
    input  logic             host_wr,
    input  logic [7:0]       host_wdata,
    input  logic             host_eom,
    input  logic             tmo_dis,
    input  logic [TMO_W-1:0] tmo_frames,
    input  logic             rx_abort_req,
    input  logic [7:0]       rx_mon,
    input  logic             rx_mx,
    input  logic             rx_mr,
    output logic [7:0]       tx_mon,
    output logic             tx_mx,
    output logic             tx_mr,
    output logic             tx_active,
    output logic             tx_ack_irq,
    output logic             tx_abort,
    output logic             tx_tmo,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic             rx_eom
);

    rx_slot_t in_slot;
    assign in_slot = '{data: rx_mon, mx: rx_mx};

    mon_hs_tx #(.TMO_W(TMO_W)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .tick       (frm_tick),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_eom   (host_eom),
        .tmo_dis    (tmo_dis),
        .tmo_frames (tmo_frames),
        .far_mr     (rx_mr),
        .mon_o      (tx_mon),
        .mx_o       (tx_mx),
        .active_o   (tx_active),
        .ack_o      (tx_ack_irq),
        .abort_o    (tx_abort),
        .tmo_o      (tx_tmo)
    );

    mon_hs_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .tick      (frm_tick),
        .slot_i    (in_slot),
        .abort_req (rx_abort_req),
        .mr_o      (tx_mr),
        .valid_o   (rx_valid),
        .data_o    (rx_data),
        .eom_o     (rx_eom)
    );

endmodule

// File: rtl/mon_hs_chk.sv
module mon_hs_chk (
    input logic       clk,
    input logic       rst,
    input logic       frm_tick,
    input logic       tmo_dis,
    input logic [7:0] rx_mon,
    input logic       rx_mx,
    input logic       rx_mr,
    input logic [7:0] tx_mon,
    input logic       tx_mx,
    input logic       tx_mr,
    input logic       tx_active,
    input logic       tx_ack_irq,
    input logic       tx_abort,
    input logic       tx_tmo,
    input logic       rx_valid,
    input logic [7:0] rx_data,
    input logic       rx_eom
);

    // R1: an inactive transmitter never drives MX active
    p_idle_mx_r1: assert property (@(posedge clk) disable iff (rst)
        !tx_active |-> tx_mx);

    // R3: an accepted byte comes from a frame with MX active and carries its value
    p_accept_src_r3: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> ($past(frm_tick) && !$past(rx_mx) && rx_data == $past(rx_mon)));

    // R3: acceptance and MR going active coincide
    p_accept_mr_r3: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> !tx_mr);

    // R4: acknowledge only after a frame with MR active
    p_ack_src_r4: assert property (@(posedge clk) disable iff (rst)
        tx_ack_irq |-> ($past(frm_tick) && !$past(rx_mr)));

    // R6: the outgoing byte is frozen while MX stays active
    p_byte_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_active && !tx_mx && $past(tx_active && !tx_mx)) |-> $stable(tx_mon));

    // R7: end of message only after an inactive MX frame, with MR released
    p_eom_src_r7: assert property (@(posedge clk) disable iff (rst)
        rx_eom |-> ($past(frm_tick) && $past(rx_mx) && tx_mr));

    // R7: a frame gives either a byte or an end of message, not both
    p_rx_excl_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rx_valid, rx_eom}));

    // R10: an abort leaves the transmitter idle with MX inactive
    p_abort_idle_r10: assert property (@(posedge clk) disable iff (rst)
        tx_abort |-> (!tx_active && tx_mx));

    // R11: a timeout is an abort and only happens with the timeout enabled
    p_tmo_abort_r11: assert property (@(posedge clk) disable iff (rst)
        tx_tmo |-> (tx_abort && !$past(tmo_dis)));

endmodule

bind mon_handshake_ctl mon_hs_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .frm_tick   (frm_tick),
    .tmo_dis    (tmo_dis),
    .rx_mon     (rx_mon),
    .rx_mx      (rx_mx),
    .rx_mr      (rx_mr),
    .tx_mon     (tx_mon),
    .tx_mx      (tx_mx),
    .tx_mr      (tx_mr),
    .tx_active  (tx_active),
    .tx_ack_irq (tx_ack_irq),
    .tx_abort   (tx_abort),
    .tx_tmo     (tx_tmo),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_eom     (rx_eom)
);

// File: tb/sim_mon_handshake_ctl.sv
`timescale 1ns/1ps
module sim_mon_handshake_ctl;

    localparam int TMO_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frm_tick = 1'b0;
    logic host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic host_eom = 1'b0;
    logic tmo_dis = 1'b0;
    logic [TMO_W-1:0] tmo_frames = 8'd8;
    logic rx_abort_req = 1'b0;
    logic lb = 1'b1;
    logic [7:0] drv_mon = '0;
    logic drv_mx = 1'b1;
    logic drv_mr = 1'b1;

    logic [7:0] rx_mon, tx_mon, rx_data;
    logic rx_mx, rx_mr, tx_mx, tx_mr, tx_active;
    logic tx_ack_irq, tx_abort, tx_tmo, rx_valid, rx_eom;

    assign rx_mon = lb ? tx_mon : drv_mon;
    assign rx_mx  = lb ? tx_mx  : drv_mx;
    assign rx_mr  = lb ? tx_mr  : drv_mr;

    always #4 clk = ~clk;

    mon_handshake_ctl #(.TMO_W(TMO_W)) u0 (
        .clk(clk), .rst(rst), .frm_tick(frm_tick),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_eom(host_eom),
        .tmo_dis(tmo_dis), .tmo_frames(tmo_frames), .rx_abort_req(rx_abort_req),
        .rx_mon(rx_mon), .rx_mx(rx_mx), .rx_mr(rx_mr),
        .tx_mon(tx_mon), .tx_mx(tx_mx), .tx_mr(tx_mr), .tx_active(tx_active),
        .tx_ack_irq(tx_ack_irq), .tx_abort(tx_abort), .tx_tmo(tx_tmo),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_eom(rx_eom)
    );

    // Pulse counters, sampled away from the active edge
    int n_valid = 0, n_ack = 0, n_eom = 0, n_abort = 0, n_tmo = 0;
    logic [7:0] last_data = '0;
    always @(negedge clk) begin
        if (rx_valid) begin n_valid++; last_data = rx_data; end
        if (tx_ack_irq) n_ack++;
        if (rx_eom) n_eom++;
        if (tx_abort) n_abort++;
        if (tx_tmo) n_tmo++;
    end

    int checks = 0, errors = 0;
    bit done = 1'b0;
    int fv, fa, fe, fab, ft;

    // {last-byte-of-message, data}
    localparam logic [8:0] TBL [6] = '{9'h03C, 9'h1A5, 9'h100, 9'h0FF, 9'h081, 9'h15A};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic frame();
        @(negedge clk) frm_tick = 1'b1;
        @(negedge clk) frm_tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Run n frames; record the frame index at which each pulse first shows
    task automatic run(input int n);
        int bv, ba, be, bab, bt;
        bv = n_valid; ba = n_ack; be = n_eom; bab = n_abort; bt = n_tmo;
        fv = 0; fa = 0; fe = 0; fab = 0; ft = 0;
        for (int i = 1; i <= n; i++) begin
            frame();
            if (fv == 0 && n_valid > bv) fv = i;
            if (fa == 0 && n_ack > ba) fa = i;
            if (fe == 0 && n_eom > be) fe = i;
            if (fab == 0 && n_abort > bab) fab = i;
            if (ft == 0 && n_tmo > bt) ft = i;
        end
    endtask

    task automatic write(input logic [7:0] d);
        @(negedge clk) begin host_wr = 1'b1; host_wdata = d; end
        @(negedge clk) host_wr = 1'b0;
    endtask

    task automatic end_msg();
        @(negedge clk) host_eom = 1'b1;
        @(negedge clk) host_eom = 1'b0;
    endtask

    // Watchdog
    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 tx_mx", tx_mx, 1);
        chk("R1 tx_mr", tx_mr, 1);
        chk("R1 tx_active", tx_active, 0);
        chk("R1 pulses", {tx_ack_irq, tx_abort, tx_tmo, rx_valid, rx_eom}, 0);

        // Table walk in loopback
        for (int i = 0; i < 6; i++) begin
            bit first;
            first = (i == 0) || TBL[(i == 0) ? 0 : i-1][8];
            write(TBL[i][7:0]);
            if (first) begin
                chk("R2 active", tx_active, 1);
                chk("R2 mx", tx_mx, 0);
                chk("R2 byte", tx_mon, TBL[i][7:0]);
            end else begin
                chk("R5 gap mx", tx_mx, 1);
                chk("R5 new byte", tx_mon, TBL[i][7:0]);
            end
            run(5);
            chk("R3 accept frame", fv, first ? 2 : 3);
            chk("R3 data", last_data, TBL[i][7:0]);
            chk("R4 ack frame", fa, first ? 3 : 4);
            chk("R4 hold mx", tx_mx, 0);
            chk("R4 hold byte", tx_mon, TBL[i][7:0]);
            if (TBL[i][8]) begin
                end_msg();
                chk("R8 eom mx", tx_mx, 1);
                base = n_eom;
                frame();
                chk("R7 mr released", tx_mr, 1);
                chk("R7 no early eom", n_eom, base);
                frame();
                chk("R7 eom", n_eom, base + 1);
                chk("R8 inactive", tx_active, 0);
            end
        end

        // R6: write while waiting for acknowledge is ignored
        write(8'h11);
        write(8'h22);
        chk("R6 byte kept", tx_mon, 8'h11);
        run(5);
        chk("R6 received", last_data, 8'h11);
        end_msg();
        run(2);
        chk("R8 closed", tx_active, 0);

        // R3: changing byte rejected (driven far end)
        lb = 1'b0;
        base = n_valid;
        drv_mx = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            drv_mon = 8'(k * 16);
            frame();
        end
        chk("R3 no accept of changing byte", n_valid, base);
        chk("R3 mr idle", tx_mr, 1);
        frame();
        chk("R3 accept repeat", n_valid, base + 1);
        chk("R3 repeat data", last_data, 8'h40);
        chk("R3 mr active", tx_mr, 0);
        drv_mx = 1'b1;
        base = n_eom;
        frame();
        chk("R7 release", tx_mr, 1);
        frame();
        chk("R7 eom driven", n_eom, base + 1);

        // R9/R10: receiver abort seen by the transmitter (loopback)
        lb = 1'b1;
        write(8'h77);
        run(5);
        chk("R10 active before abort", tx_active, 1);
        @(negedge clk) rx_abort_req = 1'b1;
        @(negedge clk) rx_abort_req = 1'b0;
        chk("R9 mr released", tx_mr, 1);
        run(2);
        chk("R10 abort frame", fab, 2);
        chk("R10 inactive", tx_active, 0);
        chk("R10 mx idle", tx_mx, 1);
        run(3);
        chk("R9 no eom", fe, 0);
        chk("R9 no accept", fv, 0);
        write(8'h66);
        run(5);
        chk("R9 resync frame", fv, 2);
        chk("R9 resync data", last_data, 8'h66);
        end_msg();
        run(2);

        // R11: timeout with a silent far end
        lb = 1'b0; drv_mx = 1'b1; drv_mr = 1'b1;
        tmo_frames = 8'd5;
        write(8'h99);
        run(7);
        chk("R11 tmo frame", ft, 5);
        chk("R11 abort frame", fab, 5);
        chk("R11 inactive", tx_active, 0);
        tmo_frames = 8'd1;
        write(8'h9A);
        run(2);
        chk("R11 tmo at limit 1", ft, 1);
        tmo_dis = 1'b1;
        write(8'h98);
        run(12);
        chk("R11 disabled no tmo", ft, 0);
        chk("R11 disabled still active", tx_active, 1);
        drv_mr = 1'b0;
        run(1);
        chk("R4 driven ack", fa, 1);
        drv_mr = 1'b1;
        end_msg();
        run(2);
        chk("R8 driven close", tx_active, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule